// File: doc/BRIEF.md
# Coarse-Grain Two-Context Thread Scheduler

This block chooses which of two hardware contexts feeds a short in-order pipeline. Each context has its own program counter and register file, and the scheduler's thread ID output selects which of them is used. Thread 0 is the favoured context. It issues for as long as it has work. When it takes a long-latency second-level cache miss, the scheduler empties the pipeline and hands the machine to thread 1. When that miss is filled, the scheduler empties the pipeline again and gives control back to thread 0.

A switch always passes through a flush. The flush lasts a fixed number of cycles equal to the pipeline depth, and no instruction issues during it. While the flush is in progress, the thread ID output still names the thread being flushed. The pipeline uses it to wind that thread's PC back to its oldest instruction that has not retired. Short stalls do not cause a switch. These include first-level misses and mispredicts, which arrive as miss reports with the long-miss flag low. If both threads are waiting on long misses at the same time, the pipeline sits idle until one of the misses is filled. Thread 0 wins any tie.

Top module: `cgmt_sched`

## Requirements
- R1: After reset, issue_en is 1, flush is 0 and sel_tid is 0 (thread 0 is the favoured context).
- R2: If the issuing thread is thread 0 and it reports a miss with miss_vld[0]=1 and miss_l2[0]=1, the cycle after that edge has flush=1 and issue_en=0. In that cycle sel_tid stays 0, naming the thread whose PC is rewound.
- R3: A flush holds flush=1 and issue_en=0 for exactly DEPTH cycles. Issue then resumes, or the block goes idle.
- R4: If thread 1 is issuing and fill_done[0] arrives while thread 0's long miss is outstanding, the block flushes with sel_tid=1 for DEPTH cycles. Thread 0 then resumes.
- R5: The following have no effect and the issuing thread keeps running: a miss with miss_l2 low, any miss report from the thread that is not issuing, and a fill_done for a thread with no outstanding long miss.
- R6: If thread 1 takes a long miss while thread 0's miss is still outstanding, the block flushes and then idles. While idle, issue_en=0 and flush=0, and sel_tid keeps the last thread.
- R7: While idle, a fill_done for either thread makes that thread issue in the next cycle without a flush.
- R8: Thread 0 has priority. If both fills arrive in the same cycle, or if thread 0's fill arrives before a flush ends, thread 0 is the one that resumes.
- R9: sel_tid changes only in a cycle in which issue resumes after a flush or after idling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 2 | Per-thread miss report strobe |
| miss_l2 | input | 2 | Per-thread flag marking the reported miss as long-latency |
| fill_done | input | 2 | Per-thread long-miss completion strobe |
| sel_tid | output | 1 | Thread whose PC and register file are in use, or which is being flushed |
| issue_en | output | 1 | Instructions may issue from sel_tid |
| flush | output | 1 | Pipeline flush in progress |

## Verification
Every output is registered. A miss or fill presented before a clock edge therefore shows up in the cycle that follows that edge. The flush output stays high for DEPTH cycles, and issue resumes in cycle DEPTH+1. A resume out of idle takes exactly one cycle. The bench applies inputs at a falling edge and checks at the next falling edge, so every check lands on the cycle in which a result is due. It checks every flush cycle one by one. It also sweeps the arrival of thread 0's fill across each offset inside a flush, expecting thread 0 to resume at the fixed end cycle every time.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
    localparam int unsigned NTHR = 2;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_IDLE  = 2'd2
    } sched_st_e;

    typedef struct packed {
        sched_st_e st;
        logic      cur;
    } sched_t;
endpackage

// File: rtl/cgmt_pend.sv
module cgmt_pend #(
    parameter int unsigned NT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] set_i,
    input  logic [NT-1:0] clr_i,
    output logic [NT-1:0] pend_o
);
    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic pend_d, pend_q;

        always_comb begin
            pend_d = (pend_q & ~clr_i[t]) | set_i[t];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= pend_d;
        end

        assign pend_o[t] = pend_q;
    end
endmodule

// File: rtl/cgmt_flush_timer.sv
module cgmt_flush_timer #(
    parameter int unsigned DEPTH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)              cnt_d = CW'(DEPTH - 1);
        else if (cnt_q != '0)     cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/cgmt_sched.sv
module cgmt_sched
    import cgmt_pkg::*;
#(
    parameter int unsigned DEPTH = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] miss_vld,
    input  logic [1:0] miss_l2,
    input  logic [1:0] fill_done,
    output logic       sel_tid,
    output logic       issue_en,
    output logic       flush
);
    sched_t            fsm_d, fsm_q;
    logic [NTHR-1:0]   run_oh;
    logic [NTHR-1:0]   long_miss;
    logic [NTHR-1:0]   pend;
    logic [NTHR-1:0]   avail;
    logic              tmr_start;
    logic              tmr_done;

    // one-hot of the thread currently issuing
    for (genvar t = 0; t < NTHR; t++) begin : g_run
        assign run_oh[t] = (fsm_q.st == ST_RUN) && (fsm_q.cur == 1'(t));
    end

    // only a long miss from the issuing thread counts
    assign long_miss = run_oh & miss_vld & miss_l2;
    // a thread is runnable if nothing is outstanding or its fill lands now
    assign avail     = ~pend | fill_done;

    cgmt_pend #(.NT(NTHR)) i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (long_miss),
        .clr_i  (fill_done),
        .pend_o (pend)
    );

    cgmt_flush_timer #(.DEPTH(DEPTH)) i_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .done_o  (tmr_done)
    );

    always_comb begin
        fsm_d     = fsm_q;
        tmr_start = 1'b0;
        unique case (fsm_q.st)
            ST_RUN: begin
                if (|long_miss) begin
                    fsm_d.st  = ST_FLUSH;
                    tmr_start = 1'b1;
                end else if (fsm_q.cur && pend[0] && fill_done[0]) begin
                    // favoured thread is back: give it the pipeline
                    fsm_d.st  = ST_FLUSH;
                    tmr_start = 1'b1;
                end
            end
            ST_FLUSH, ST_IDLE: begin
                if (fsm_q.st == ST_IDLE || tmr_done) begin
                    if (avail[0]) begin
                        fsm_d.st  = ST_RUN;
                        fsm_d.cur = 1'b0;
                    end else if (avail[1]) begin
                        fsm_d.st  = ST_RUN;
                        fsm_d.cur = 1'b1;
                    end else begin
                        fsm_d.st  = ST_IDLE;
                    end
                end
            end
            default: fsm_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st  <= ST_RUN;
            fsm_q.cur <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sel_tid  = fsm_q.cur;
    assign issue_en = (fsm_q.st == ST_RUN);
    assign flush    = (fsm_q.st == ST_FLUSH);
endmodule

// File: rtl/cgmt_sched_chk.sv
module cgmt_sched_chk #(
    parameter int unsigned DEPTH = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] miss_vld,
    input logic [1:0] miss_l2,
    input logic       sel_tid,
    input logic       issue_en,
    input logic       flush
);
    localparam int unsigned FW = $clog2(DEPTH + 1) + 1;

    logic [FW-1:0] fl_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     fl_cnt_q <= '0;
        else if (flush) fl_cnt_q <= fl_cnt_q + FW'(1);
        else            fl_cnt_q <= '0;
    end

    a_r3_no_issue_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue_en, flush}));

    a_r3_flush_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush) |-> fl_cnt_q == FW'(DEPTH));

    a_r3_flush_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cnt_q <= FW'(DEPTH));

    a_r2_long_miss_flush: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en && !sel_tid && miss_vld[0] && miss_l2[0] |=> flush && !sel_tid);

    a_r5_short_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en && !sel_tid && !(miss_vld[0] && miss_l2[0]) |=> issue_en && !sel_tid);

    a_r9_sel_moves_on_resume: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_tid) |-> issue_en && !$past(issue_en));
endmodule

bind cgmt_sched cgmt_sched_chk #(.DEPTH(DEPTH)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .miss_vld (miss_vld),
    .miss_l2  (miss_l2),
    .sel_tid  (sel_tid),
    .issue_en (issue_en),
    .flush    (flush)
);

// File: tb/test_cgmt_sched.sv
module test_cgmt_sched;
    localparam int unsigned DEPTH = 5;
    // state codes: issue_en*4 + flush*2 + sel_tid
    localparam int RUN0 = 4, RUN1 = 5, FL0 = 2, FL1 = 3, IDLE1 = 1, IDLE0 = 0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] miss_vld = '0;
    logic [1:0] miss_l2 = '0;
    logic [1:0] fill_done = '0;
    logic       sel_tid, issue_en, flush;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    cgmt_sched #(.DEPTH(DEPTH)) i_cgmt_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss_vld  (miss_vld),
        .miss_l2   (miss_l2),
        .fill_done (fill_done),
        .sel_tid   (sel_tid),
        .issue_en  (issue_en),
        .flush     (flush)
    );

    function automatic int code();
        return int'(issue_en) * 4 + int'(flush) * 2 + int'(sel_tid);
    endfunction

    task automatic chk(input string req, input int exp);
        int act;
        act = code();
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s state(issue,flush,sel) actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; applies inputs across one rising edge
    task automatic step(input logic [1:0] v, input logic [1:0] l2, input logic [1:0] fd);
        miss_vld  = v;
        miss_l2   = l2;
        fill_done = fd;
        @(negedge clk);
        miss_vld  = '0;
        miss_l2   = '0;
        fill_done = '0;
    endtask

    // walk a flush cycle by cycle; fill fd is presented at offset off
    task automatic walk_flush(input string req, input int exp, input int off, input logic [1:0] fd);
        for (int k = 0; k < int'(DEPTH); k++) begin
            chk(req, exp);
            step(2'b00, 2'b00, (k == off) ? fd : 2'b00);
        end
    endtask

    initial begin
        #100000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail + 1, nchk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset", RUN0);

        // R5: ignored events while thread 0 runs
        step(2'b01, 2'b00, 2'b00); chk("R5 short miss", RUN0);
        step(2'b10, 2'b10, 2'b00); chk("R5 idle-thread miss", RUN0);
        step(2'b00, 2'b00, 2'b01); chk("R5 spurious fill0", RUN0);
        step(2'b00, 2'b00, 2'b10); chk("R5 spurious fill1", RUN0);

        // R2 / R3: long miss on thread 0
        step(2'b01, 2'b01, 2'b00);
        chk("R2 flush starts", FL0);
        walk_flush("R3 flush0", FL0, -1, 2'b00);
        chk("R3 R9 thread1 issues", RUN1);

        step(2'b10, 2'b00, 2'b00); chk("R5 short miss t1", RUN1);
        step(2'b00, 2'b00, 2'b10); chk("R5 spurious fill1 t1", RUN1);

        // R4: switch back
        step(2'b00, 2'b00, 2'b01);
        walk_flush("R4 flush1", FL1, -1, 2'b00);
        chk("R4 thread0 back", RUN0);

        // R8 sweep: fill of thread 0 at each flush offset
        for (int off = 0; off < int'(DEPTH); off++) begin
            step(2'b01, 2'b01, 2'b00);
            walk_flush("R8 sweep flush", FL0, off, 2'b01);
            chk("R8 sweep resume0", RUN0);
        end

        // R6 / R7: both threads miss
        step(2'b01, 2'b01, 2'b00);
        walk_flush("R3 flush0", FL0, -1, 2'b00);
        chk("R3 thread1 issues", RUN1);
        step(2'b10, 2'b10, 2'b00);
        walk_flush("R6 flush1", FL1, -1, 2'b00);
        for (int i = 0; i < 3; i++) begin
            chk("R6 idle", IDLE1);
            step(2'b00, 2'b00, 2'b00);
        end
        step(2'b00, 2'b00, 2'b10);
        chk("R7 resume1", RUN1);
        step(2'b10, 2'b10, 2'b00);
        walk_flush("R6 flush1 again", FL1, -1, 2'b00);
        chk("R6 idle again", IDLE1);
        step(2'b00, 2'b00, 2'b11);
        chk("R8 tie goes to 0", RUN0);

        // R7: thread 0 fill from idle, then idle again, then thread 1 fill
        step(2'b01, 2'b01, 2'b00);
        walk_flush("R3 flush0", FL0, -1, 2'b00);
        step(2'b10, 2'b10, 2'b00);
        walk_flush("R6 flush1", FL1, -1, 2'b00);
        chk("R6 idle", IDLE1);
        step(2'b00, 2'b00, 2'b01);
        chk("R7 resume0", RUN0);
        step(2'b01, 2'b01, 2'b00);
        walk_flush("R6 flush0 to idle", FL0, -1, 2'b00);
        chk("R6 idle sel0", IDLE0);
        step(2'b00, 2'b00, 2'b10);
        chk("R7 R9 resume1", RUN1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule